// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits between a CPU-side address and the rest of a chip's interconnect. It compares each lookup address against eight address windows that software programs. Each window has a base, a size in 64 KiB steps, a target ID and an attribute byte. The result is registered and appears one cycle after the lookup. It reports whether any window hit, which window won, that window's target ID and attribute, and a 64-bit translated address. Windows 0 and 1 can also relocate their range to a different place in a 64-bit space. The other windows pass the address through unchanged.

Software programs the windows through a register port. The port selects a window and one of its four registers. To move a window safely, software disables it, writes the new base (and remap values) and then writes the control word again. Base and remap writes are held back in staging registers. They reach the live comparator only when the window's control register is next written. A half-updated window therefore never decodes with a mix of old and new values.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, every window is disabled. Every register reads back zero, and res_valid, res_hit, res_win, res_target, res_attr and res_addr are all zero.
- R2: cfg_win selects a window and cfg_sel selects a register: 0 is control, 1 is base, 2 is remap-low and 3 is remap-high. Control bit 0 is enable, bits 7:4 are the target ID, bits 15:8 are the attribute and bits 31:16 are the size mask. Control bits 3:1 read back zero. Base and remap-low keep bits 31:16 only, and their bits 15:0 read back zero. cfg_rdata returns, one cycle later, the register addressed by cfg_win and cfg_sel.
- R3: Only windows 0 and 1 hold remap registers. On windows 2 to 7, writes to selectors 2 and 3 are ignored, and those selectors read back zero.
- R4: An enabled window hits when the lookup address bits 31:16 equal the base bits 31:16 on every bit where the size mask is 0. A size mask of 0x0000 covers 64 KiB, 0x000F covers 1 MiB and 0x00FF covers 16 MiB.
- R5: A window whose enable bit is clear never hits, whatever its base and size.
- R6: A write to a window's base, remap-low or remap-high register does not affect decoding until the next write to that window's control register. Readback returns the newly written value at once.
- R7: When several enabled windows hit, the one with the lowest index is reported.
- R8: For windows 0 and 1, res_addr is {remap_hi, (remap_lo[31:16] & ~size) | (addr[31:16] & size), addr[15:0]}. With remap-low equal to base and remap-high zero, the translation is the identity.
- R9: For windows 2 to 7, res_addr bits 63:32 are zero and bits 31:0 equal the lookup address.
- R10: On a miss, res_hit, res_win, res_target, res_attr and res_addr are all zero.
- R11: A lookup presented with lk_valid high yields res_valid high with its result on the next clock cycle. In every other cycle res_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_win | input | 3 | Window index for register write and read |
| cfg_sel | input | 2 | Register selector (0 control, 1 base, 2 remap-low, 3 remap-high) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for cfg_win/cfg_sel |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Lookup address |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_hit | output | 1 | Some enabled window matched |
| res_win | output | 3 | Index of the winning window |
| res_target | output | 4 | Target ID of the winning window |
| res_attr | output | 8 | Attribute byte of the winning window |
| res_addr | output | 64 | Translated address |

## Verification
The staged-base behaviour is the hardest case to reach from the ports. A base write must leave the live window untouched while readback already shows the new value. The bench takes a window that is enabled and hitting and writes a new base without touching its control word. It then looks up both the old and the new range and reads the base back. Only after that does it rewrite the control word and repeat both lookups. For overlap priority, the stimulus places a large window at a higher index over a smaller one at a lower index. It probes addresses inside both windows and inside only the larger one. Last, it enables a window with an all-ones mask that covers the entire space.

// File: rtl/awd_pkg.sv
package awd_pkg;

  // Register selector codes; the encoding is visible to software.
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_RLO  = 2'd2,
    SEL_RHI  = 2'd3
  } awd_sel_e;

  // Control word field positions.
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_TGT_LSB  = 4;
  localparam int CTRL_TGT_W    = 4;
  localparam int CTRL_ATTR_LSB = 8;
  localparam int CTRL_ATTR_W   = 8;
  localparam int CTRL_SIZE_LSB = 16;

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  parameter int ADDR_W    = 32,
  parameter int MASK_W    = 16,
  parameter int TGT_W     = CTRL_TGT_W,
  parameter int ATTR_W    = CTRL_ATTR_W,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int OFS_W    = ADDR_W - MASK_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              win_sel,
  input  logic [1:0]                    reg_sel,
  input  logic [ADDR_W-1:0]             wr_data,
  output logic [ADDR_W-1:0]             rd_data,
  output logic [NUM_WIN-1:0]            en_vec,
  output logic [NUM_WIN-1:0][MASK_W-1:0] size_vec,
  output logic [NUM_WIN-1:0][TGT_W-1:0]  tgt_vec,
  output logic [NUM_WIN-1:0][ATTR_W-1:0] attr_vec,
  output logic [NUM_WIN-1:0][MASK_W-1:0] base_vec,
  output logic [NUM_WIN-1:0][MASK_W-1:0] rlo_vec,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] rhi_vec
);

  // Control fields (live immediately on write)
  logic                 en_q   [NUM_WIN];
  logic [TGT_W-1:0]     tgt_q  [NUM_WIN];
  logic [ATTR_W-1:0]    attr_q [NUM_WIN];
  logic [MASK_W-1:0]    size_q [NUM_WIN];
  // Base: staged copy seen by software, live copy seen by the comparator
  logic [MASK_W-1:0]    base_stg [NUM_WIN];
  logic [MASK_W-1:0]    base_act [NUM_WIN];
  // Remap registers exist only for the first NUM_REMAP windows
  logic [MASK_W-1:0]    rlo_stg [NUM_REMAP];
  logic [MASK_W-1:0]    rlo_act [NUM_REMAP];
  logic [ADDR_W-1:0]    rhi_stg [NUM_REMAP];
  logic [ADDR_W-1:0]    rhi_act [NUM_REMAP];

  logic [ADDR_W-1:0]    rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        en_q[w]     <= 1'b0;
        tgt_q[w]    <= '0;
        attr_q[w]   <= '0;
        size_q[w]   <= '0;
        base_stg[w] <= '0;
        base_act[w] <= '0;
      end
      for (int r = 0; r < NUM_REMAP; r++) begin
        rlo_stg[r] <= '0;
        rlo_act[r] <= '0;
        rhi_stg[r] <= '0;
        rhi_act[r] <= '0;
      end
    end else if (wr_en) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (int'(win_sel) == w) begin
          unique case (awd_sel_e'(reg_sel))
            SEL_CTRL: begin
              en_q[w]     <= wr_data[CTRL_EN_BIT];
              tgt_q[w]    <= wr_data[CTRL_TGT_LSB +: TGT_W];
              attr_q[w]   <= wr_data[CTRL_ATTR_LSB +: ATTR_W];
              size_q[w]   <= wr_data[CTRL_SIZE_LSB +: MASK_W];
              base_act[w] <= base_stg[w];
            end
            SEL_BASE: base_stg[w] <= wr_data[OFS_W +: MASK_W];
            default: ;
          endcase
        end
      end
      for (int r = 0; r < NUM_REMAP; r++) begin
        if (int'(win_sel) == r) begin
          unique case (awd_sel_e'(reg_sel))
            SEL_CTRL: begin
              rlo_act[r] <= rlo_stg[r];
              rhi_act[r] <= rhi_stg[r];
            end
            SEL_RLO: rlo_stg[r] <= wr_data[OFS_W +: MASK_W];
            SEL_RHI: rhi_stg[r] <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  // Readback returns the software-visible (staged) values.
  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (int'(win_sel) == w) begin
        unique case (awd_sel_e'(reg_sel))
          SEL_CTRL: begin
            rd_mux[CTRL_EN_BIT]                 = en_q[w];
            rd_mux[CTRL_TGT_LSB +: TGT_W]       = tgt_q[w];
            rd_mux[CTRL_ATTR_LSB +: ATTR_W]     = attr_q[w];
            rd_mux[CTRL_SIZE_LSB +: MASK_W]     = size_q[w];
          end
          SEL_BASE: rd_mux[OFS_W +: MASK_W] = base_stg[w];
          default: ;
        endcase
      end
    end
    for (int r = 0; r < NUM_REMAP; r++) begin
      if (int'(win_sel) == r) begin
        if (awd_sel_e'(reg_sel) == SEL_RLO) rd_mux[OFS_W +: MASK_W] = rlo_stg[r];
        if (awd_sel_e'(reg_sel) == SEL_RHI) rd_mux = rhi_stg[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // Export live values; non-remap windows see tied-off remap fields.
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_exp
    assign en_vec[w]   = en_q[w];
    assign size_vec[w] = size_q[w];
    assign tgt_vec[w]  = tgt_q[w];
    assign attr_vec[w] = attr_q[w];
    assign base_vec[w] = base_act[w];
    if (w < NUM_REMAP) begin : g_rm
      assign rlo_vec[w] = rlo_act[w];
      assign rhi_vec[w] = rhi_act[w];
    end else begin : g_nrm
      assign rlo_vec[w] = '0;
      assign rhi_vec[w] = '0;
    end
  end

endmodule

// File: rtl/awd_match.sv
module awd_match #(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  parameter int ADDR_W    = 32,
  parameter int MASK_W    = 16
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_WIN-1:0]              en_vec,
  input  logic [NUM_WIN-1:0][MASK_W-1:0]  size_vec,
  input  logic [NUM_WIN-1:0][MASK_W-1:0]  base_vec,
  input  logic [NUM_WIN-1:0][MASK_W-1:0]  rlo_vec,
  output logic [NUM_WIN-1:0]              hit_vec,
  output logic [NUM_WIN-1:0][MASK_W-1:0]  xpage_vec
);

  localparam int OFS_W = ADDR_W - MASK_W;

  logic [MASK_W-1:0] page;
  assign page = addr[OFS_W +: MASK_W];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [MASK_W-1:0] fixed_bits;
    assign fixed_bits = ~size_vec[w];
    assign hit_vec[w] = en_vec[w] &&
                        ((page & fixed_bits) == (base_vec[w] & fixed_bits));
    if (w < NUM_REMAP) begin : g_xl
      assign xpage_vec[w] = (rlo_vec[w] & fixed_bits) | (page & size_vec[w]);
    end else begin : g_pass
      assign xpage_vec[w] = page;
    end
  end

endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  // Scan from the top down so the lowest set index is kept last.
  always_comb begin
    idx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (req[w]) idx = IDX_W'(w);
    end
  end

  assign any = |req;

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  parameter int ADDR_W    = 32,
  parameter int MASK_W    = 16,
  parameter int TGT_W     = CTRL_TGT_W,
  parameter int ATTR_W    = CTRL_ATTR_W,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int OFS_W    = ADDR_W - MASK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [IDX_W-1:0]     cfg_win,
  input  logic [1:0]           cfg_sel,
  input  logic [ADDR_W-1:0]    cfg_wdata,
  output logic [ADDR_W-1:0]    cfg_rdata,
  input  logic                 lk_valid,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic [IDX_W-1:0]     res_win,
  output logic [TGT_W-1:0]     res_target,
  output logic [ATTR_W-1:0]    res_attr,
  output logic [2*ADDR_W-1:0]  res_addr
);

  logic [NUM_WIN-1:0]              en_vec;
  logic [NUM_WIN-1:0][MASK_W-1:0]  size_vec;
  logic [NUM_WIN-1:0][TGT_W-1:0]   tgt_vec;
  logic [NUM_WIN-1:0][ATTR_W-1:0]  attr_vec;
  logic [NUM_WIN-1:0][MASK_W-1:0]  base_vec;
  logic [NUM_WIN-1:0][MASK_W-1:0]  rlo_vec;
  logic [NUM_WIN-1:0][ADDR_W-1:0]  rhi_vec;
  logic [NUM_WIN-1:0]              hit_vec;
  logic [NUM_WIN-1:0][MASK_W-1:0]  xpage_vec;
  logic                            any_hit;
  logic [IDX_W-1:0]                win_idx;

  awd_regfile #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .ADDR_W(ADDR_W),
    .MASK_W(MASK_W), .TGT_W(TGT_W), .ATTR_W(ATTR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr),
    .win_sel  (cfg_win),
    .reg_sel  (cfg_sel),
    .wr_data  (cfg_wdata),
    .rd_data  (cfg_rdata),
    .en_vec   (en_vec),
    .size_vec (size_vec),
    .tgt_vec  (tgt_vec),
    .attr_vec (attr_vec),
    .base_vec (base_vec),
    .rlo_vec  (rlo_vec),
    .rhi_vec  (rhi_vec)
  );

  awd_match #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .ADDR_W(ADDR_W), .MASK_W(MASK_W)
  ) u_match (
    .addr      (lk_addr),
    .en_vec    (en_vec),
    .size_vec  (size_vec),
    .base_vec  (base_vec),
    .rlo_vec   (rlo_vec),
    .hit_vec   (hit_vec),
    .xpage_vec (xpage_vec)
  );

  awd_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .req (hit_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_win    <= '0;
      res_target <= '0;
      res_attr   <= '0;
      res_addr   <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid && any_hit) begin
        res_hit    <= 1'b1;
        res_win    <= win_idx;
        res_target <= tgt_vec[win_idx];
        res_attr   <= attr_vec[win_idx];
        res_addr   <= {rhi_vec[win_idx], xpage_vec[win_idx], lk_addr[OFS_W-1:0]};
      end else begin
        res_hit    <= 1'b0;
        res_win    <= '0;
        res_target <= '0;
        res_attr   <= '0;
        res_addr   <= '0;
      end
    end
  end

endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  parameter int ADDR_W    = 32,
  parameter int TGT_W     = 4,
  parameter int ATTR_W    = 8,
  localparam int IDX_W    = $clog2(NUM_WIN)
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          cfg_sel,
  input logic [ADDR_W-1:0]   cfg_rdata,
  input logic                lk_valid,
  input logic                res_valid,
  input logic                res_hit,
  input logic [IDX_W-1:0]    res_win,
  input logic [TGT_W-1:0]    res_target,
  input logic [ATTR_W-1:0]   res_attr,
  input logic [2*ADDR_W-1:0] res_addr,
  input logic [NUM_WIN-1:0]  en_vec,
  input logic [NUM_WIN-1:0]  hit_vec
);

  p_rdata_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_sel) == 2'd1 || $past(cfg_sel) == 2'd2) |-> cfg_rdata[15:0] == 16'h0);

  p_disabled_no_hit_r5: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> ((($past(en_vec) >> res_win) & NUM_WIN'(1)) != '0));

  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (($past(hit_vec) & ((NUM_WIN'(1) << res_win) - NUM_WIN'(1))) == '0));

  p_pass_through_r9: assert property (@(posedge clk) disable iff (rst)
    (res_hit && int'(res_win) >= NUM_REMAP) |-> res_addr[2*ADDR_W-1:ADDR_W] == '0);

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |->
      (res_addr == '0 && res_target == '0 && res_attr == '0 && res_win == '0));

  p_valid_next_r11: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!res_valid && !res_hit));

endmodule

bind addr_window_decoder awd_checker #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .ADDR_W(ADDR_W),
  .TGT_W(TGT_W), .ATTR_W(ATTR_W)
) u_awd_checker (
  .clk        (clk),
  .rst        (rst),
  .cfg_sel    (cfg_sel),
  .cfg_rdata  (cfg_rdata),
  .lk_valid   (lk_valid),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_win    (res_win),
  .res_target (res_target),
  .res_attr   (res_attr),
  .res_addr   (res_addr),
  .en_vec     (en_vec),
  .hit_vec    (hit_vec)
);

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit;
  logic [2:0]  res_win;
  logic [3:0]  res_target;
  logic [7:0]  res_attr;
  logic [63:0] res_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_decoder u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_win(res_win), .res_target(res_target), .res_attr(res_attr),
    .res_addr(res_addr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic [2:0]  win;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [63:0] xa;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t TBL [NVEC] = '{
    '{32'h1050_1234, 1'b1, 3'd0, 4'h4, 8'hE8, 64'h0000_0001_8050_1234}, // R8 R7 overlap W0/W2
    '{32'h10FF_FFFF, 1'b1, 3'd0, 4'h4, 8'hE8, 64'h0000_0001_80FF_FFFF}, // R8 top of 16 MiB
    '{32'h1100_0000, 1'b1, 3'd2, 4'h3, 8'h11, 64'h0000_0000_1100_0000}, // R4 R9
    '{32'h13FF_FFFC, 1'b1, 3'd2, 4'h3, 8'h11, 64'h0000_0000_13FF_FFFC}, // R4
    '{32'h1400_0000, 1'b0, 3'd0, 4'h0, 8'h00, 64'h0},                    // R10
    '{32'h2000_ABCD, 1'b1, 3'd1, 4'h4, 8'h59, 64'h0000_0000_2000_ABCD}, // R8 identity
    '{32'h2001_0000, 1'b0, 3'd0, 4'h0, 8'h00, 64'h0},                    // R4 64 KiB edge
    '{32'h3000_0010, 1'b0, 3'd0, 4'h0, 8'h00, 64'h0},                    // R5 disabled
    '{32'h400F_0000, 1'b1, 3'd4, 4'h1, 8'h0F, 64'h0000_0000_400F_0000}, // R4 1 MiB
    '{32'h4010_0000, 1'b0, 3'd0, 4'h0, 8'h00, 64'h0},                    // R4 past 1 MiB
    '{32'hFF12_3456, 1'b1, 3'd7, 4'h1, 8'h1D, 64'h0000_0000_FF12_3456}, // R9
    '{32'h0FFF_FFFF, 1'b0, 3'd0, 4'h0, 8'h00, 64'h0}                     // R10
  };

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(int w, int s, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_win = 3'(w); cfg_sel = 2'(s); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(int w, int s, output logic [31:0] d);
    @(negedge clk);
    cfg_win = 3'(w); cfg_sel = 2'(s);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic lookup(logic [31:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_res(string req, logic h, logic [2:0] w, logic [3:0] t,
                            logic [7:0] at, logic [63:0] xa);
    check(req, {res_valid, res_hit, res_win, res_target, res_attr, res_addr},
               {1'b1, h, w, t, at, xa});
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state at the outputs
    check("R1", {res_valid, res_hit, res_win, res_target, res_attr, res_addr}, '0);
    rst = 1'b0;
    cfg_read(0, 0, rd); check("R1", rd, 32'h0);
    cfg_read(1, 3, rd); check("R1", rd, 32'h0);
    lookup(32'h0000_0000);
    expect_res("R1", 1'b0, 3'd0, 4'h0, 8'h00, 64'h0);

    // Program windows: base/remap first, control last.
    cfg_write(0, 1, 32'h1000_0000); cfg_write(0, 2, 32'h8000_0000);
    cfg_write(0, 3, 32'h0000_0001); cfg_write(0, 0, 32'h00FF_E841);
    cfg_write(1, 1, 32'h2000_0000); cfg_write(1, 2, 32'h2000_0000);
    cfg_write(1, 3, 32'h0000_0000); cfg_write(1, 0, 32'h0000_5941);
    cfg_write(2, 1, 32'h1000_0000); cfg_write(2, 0, 32'h03FF_1131);
    cfg_write(3, 1, 32'h3000_0000); cfg_write(3, 0, 32'h0000_FF30);
    cfg_write(4, 1, 32'h4000_0000); cfg_write(4, 0, 32'h000F_0F11);
    cfg_write(7, 1, 32'hFF00_0000); cfg_write(7, 0, 32'h00FF_1D11);

    // R11: idle cycle gives no valid
    @(negedge clk);
    check("R11", {res_valid, res_hit}, 2'b00);

    for (int i = 0; i < NVEC; i++) begin
      lookup(TBL[i].addr);
      expect_res(!TBL[i].hit ? "R10" : (TBL[i].win < 3'd2 ? "R8" : "R4"),
                 TBL[i].hit, TBL[i].win, TBL[i].tgt, TBL[i].attr, TBL[i].xa);
    end

    // R2: readback masks
    cfg_read(0, 0, rd); check("R2", rd, 32'h00FF_E841);
    cfg_read(3, 0, rd); check("R2", rd, 32'h0000_FF30);
    cfg_write(5, 1, 32'h1234_5678);
    cfg_read(5, 1, rd); check("R2", rd, 32'h1234_0000);
    cfg_read(0, 2, rd); check("R2", rd, 32'h8000_0000);
    cfg_read(0, 3, rd); check("R2", rd, 32'h0000_0001);

    // R3: no remap storage on windows 2..7
    cfg_write(5, 2, 32'hDEAD_BEEF); cfg_write(5, 3, 32'hCAFE_F00D);
    cfg_read(5, 2, rd); check("R3", rd, 32'h0);
    cfg_read(5, 3, rd); check("R3", rd, 32'h0);

    // R6: base write staged until the next control write
    cfg_write(4, 1, 32'h5000_0000);
    lookup(32'h4000_0000);
    expect_res("R6", 1'b1, 3'd4, 4'h1, 8'h0F, 64'h0000_0000_4000_0000);
    lookup(32'h5000_0000);
    expect_res("R6", 1'b0, 3'd0, 4'h0, 8'h00, 64'h0);
    cfg_read(4, 1, rd); check("R6", rd, 32'h5000_0000);
    cfg_write(4, 0, 32'h000F_0F11);
    lookup(32'h5000_0000);
    expect_res("R6", 1'b1, 3'd4, 4'h1, 8'h0F, 64'h0000_0000_5000_0000);
    lookup(32'h4000_0000);
    expect_res("R6", 1'b0, 3'd0, 4'h0, 8'h00, 64'h0);

    // R6: remap staged on window 0
    cfg_write(0, 3, 32'h0000_0002);
    lookup(32'h1000_0010);
    expect_res("R6", 1'b1, 3'd0, 4'h4, 8'hE8, 64'h0000_0001_8000_0010);
    cfg_write(0, 0, 32'h00FF_E841);
    lookup(32'h1000_0010);
    expect_res("R8", 1'b1, 3'd0, 4'h4, 8'hE8, 64'h0000_0002_8000_0010);

    // R5: disabling window 4 removes its hit
    cfg_write(4, 0, 32'h000F_0F10);
    lookup(32'h5000_0000);
    expect_res("R5", 1'b0, 3'd0, 4'h0, 8'h00, 64'h0);

    // R2 control bits 3:1 and R7 catch-all window
    cfg_write(3, 0, 32'hFFFF_FFFF);
    cfg_read(3, 0, rd); check("R2", rd, 32'hFFFF_FFF1);
    lookup(32'h1400_0000);
    expect_res("R7", 1'b1, 3'd3, 4'hF, 8'hFF, 64'h0000_0000_1400_0000);
    lookup(32'h1050_0000);
    expect_res("R7", 1'b1, 3'd0, 4'h4, 8'hE8, 64'h0000_0002_8050_0000);
    lookup(32'hFF00_0000);
    expect_res("R7", 1'b1, 3'd3, 4'hF, 8'hFF, 64'h0000_0000_FF00_0000);

    // R1: reset clears programmed state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    cfg_read(0, 0, rd); check("R1", rd, 32'h0);
    lookup(32'h1050_0000);
    expect_res("R1", 1'b0, 3'd0, 4'h0, 8'h00, 64'h0);

    done = 1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule